// File: doc/BRIEF.md
# Test Pattern Injection Sequencer

This block steps through a 256-entry pattern memory per channel so that stored test words can stand in for digitised samples during calibration. Each channel owns its own memory of 16-bit words, of which the low 12 bits carry data. A host loads every channel's memory through a plain write port. All channels share one read address, so on each clock the block presents one word per channel, side by side on a wide output bus.

Three configuration inputs choose how the shared address moves once a sequence is started by a test-sequence command pulse. A global enable gates everything. The mode picks the event that advances the address: every clock, each trigger pulse, or each further command pulse. The loop bit decides whether the address wraps from the last entry back to zero or ends the sequence there. The memory read is synchronous, so the sequence-active output is delayed by one clock and marks the cycles whose data belong to the sequence.

Top module: `tinj_sequencer`

## Requirements
- R1: While rst_n is low, ram_addr_o is 0, seq_active_o is 0 and pattern_o is all zero.
- R2: With no sequence running, ram_addr_o is held at 0. A sequence starts only on a clock edge where cfg_enable is 1 and test_cmd_i is 1. While cfg_enable is 0, command pulses have no effect, and a running sequence returns to idle (address 0) at the next edge.
- R3: Mode 2'b00 with cfg_loop 0 (one-shot): the starting edge sets the address to 0, each later edge adds 1, and the edge after address 255 ends the sequence. The internal sequence is active for exactly 256 clocks.
- R4: Mode 2'b00 with cfg_loop 1: after 255 the address goes to 0 and the sequence stays active.
- R5: A test_cmd_i pulse during an active sequence in mode 2'b00, 2'b01 or 2'b11 changes neither the address nor the activity.
- R6: Mode 2'b01 (trigger-stepped): the address advances by 1 only on edges where l0_i is 1 and holds otherwise. A trigger at address 255 ends the sequence when cfg_loop is 0 and wraps to 0 when cfg_loop is 1.
- R7: Mode 2'b10 (command-stepped): after the starting pulse, each further test_cmd_i pulse advances the address by 1. The address wraps from 255 to 0 whatever cfg_loop holds.
- R8: Mode 2'b11 behaves exactly as mode 2'b00.
- R9: Channel c's word occupies pattern_o[16c+15:16c]. The word stored at the address shown on ram_addr_o in one cycle appears on pattern_o in the next cycle, and seq_active_o in that next cycle equals the internal activity of the cycle before.
- R10: Bits 15:12 of every channel lane on pattern_o are always 0.
- R11: A clock edge with host_we_i 1 stores host_data_i into channel host_chan_i at address host_addr_i. Later reads of that address return the stored word's low 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (one address step per cycle in free mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Global permission to run a sequence |
| cfg_loop | input | 1 | Wrap at the last address instead of ending |
| cfg_mode | input | 2 | Advance source: 00 clock, 01 trigger, 10 command, 11 as 00 |
| test_cmd_i | input | 1 | Test-sequence command pulse (start, or step in mode 10) |
| l0_i | input | 1 | Trigger pulse used as step in mode 01 |
| host_we_i | input | 1 | Host write strobe |
| host_chan_i | input | 3 | Host write channel select |
| host_addr_i | input | 8 | Host write address |
| host_data_i | input | 16 | Host write data |
| ram_addr_o | output | 8 | Shared pattern memory read address |
| seq_active_o | output | 1 | Sequence activity, aligned with pattern_o |
| pattern_o | output | 128 | One 16-bit masked word per channel |

## Verification
The address and the internal activity change on the very edge that samples a start, step or disable, so ram_addr_o is compared at the falling edge right after that rising edge. pattern_o and seq_active_o come one register later. The bench therefore keeps the address and activity it expected one cycle before, and checks the delayed outputs against those values. Expected addresses are worked out from counts of applied clocks, trigger pulses and command pulses, not from any model of the control logic.

// File: rtl/tinj_pkg.sv
package tinj_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_TRIG = 2'b01,
        MODE_CMD  = 2'b10,
        MODE_ALT  = 2'b11
    } tinj_mode_e;

endpackage

// File: rtl/tinj_addr_ctrl.sv
module tinj_addr_ctrl
    import tinj_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              loop,
    input  tinj_mode_e        mode,
    input  logic              cmd,
    input  logic              trig,
    output logic [ADDR_W-1:0] addr_o,
    output logic              active_o
);

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  step;
    logic  wrap_ok;

    always_comb begin
        case (mode)
            MODE_TRIG: step = trig;
            MODE_CMD:  step = cmd;
            default:   step = 1'b1;
        endcase
        wrap_ok = (mode == MODE_CMD) || loop;

        st_d = st_q;
        if (!enable) begin
            st_d.active = 1'b0;
            st_d.addr   = '0;
        end else if (!st_q.active) begin
            if (cmd) begin
                st_d.active = 1'b1;
                st_d.addr   = '0;
            end
        end else if (step) begin
            if (st_q.addr == LAST) begin
                st_d.addr = '0;
                if (!wrap_ok) begin
                    st_d.active = 1'b0;
                end
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o   = st_q.addr;
    assign active_o = st_q.active;

endmodule

// File: rtl/tinj_chan_ram.sv
module tinj_chan_ram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned USED_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [WORD_W-1:0] KEEP =
        {{(WORD_W-USED_W){1'b0}}, {USED_W{1'b1}}};

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rd_d = mem[raddr] & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q;

endmodule

// File: rtl/tinj_sequencer.sv
module tinj_sequencer
    import tinj_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_CH   = 8,
    parameter int unsigned USED_W = 12,
    localparam int unsigned CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_enable,
    input  logic                   cfg_loop,
    input  logic [1:0]             cfg_mode,
    input  logic                   test_cmd_i,
    input  logic                   l0_i,
    input  logic                   host_we_i,
    input  logic [CH_W-1:0]        host_chan_i,
    input  logic [ADDR_W-1:0]      host_addr_i,
    input  logic [WORD_W-1:0]      host_data_i,
    output logic [ADDR_W-1:0]      ram_addr_o,
    output logic                   seq_active_o,
    output logic [N_CH*WORD_W-1:0] pattern_o
);

    logic [ADDR_W-1:0] seq_addr;
    logic              seq_act;
    logic              act_d, act_q;

    tinj_addr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_enable),
        .loop     (cfg_loop),
        .mode     (tinj_mode_e'(cfg_mode)),
        .cmd      (test_cmd_i),
        .trig     (l0_i),
        .addr_o   (seq_addr),
        .active_o (seq_act)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic we_c;
        assign we_c = host_we_i && (host_chan_i == CH_W'(c));

        tinj_chan_ram #(
            .ADDR_W (ADDR_W),
            .WORD_W (WORD_W),
            .USED_W (USED_W)
        ) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_c),
            .waddr (host_addr_i),
            .wdata (host_data_i),
            .raddr (seq_addr),
            .rdata (pattern_o[c*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        act_d = seq_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= act_d;
        end
    end

    assign ram_addr_o   = seq_addr;
    assign seq_active_o = act_q;

endmodule

// File: rtl/tinj_sequencer_chk.sv
module tinj_sequencer_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned N_CH   = 8,
    parameter int unsigned USED_W = 12,
    parameter int unsigned WORD_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_enable,
    input logic                   cfg_loop,
    input logic [1:0]             cfg_mode,
    input logic                   test_cmd_i,
    input logic                   l0_i,
    input logic [ADDR_W-1:0]      ram_addr_o,
    input logic                   seq_active_o,
    input logic [N_CH*WORD_W-1:0] pattern_o,
    input logic                   seq_act
);

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    function automatic logic [N_CH*WORD_W-1:0] unused_mask();
        logic [N_CH*WORD_W-1:0] m;
        m = '0;
        for (int c = 0; c < N_CH; c++) begin
            for (int b = USED_W; b < WORD_W; b++) begin
                m[c*WORD_W + b] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [N_CH*WORD_W-1:0] UNUSED = unused_mask();

    logic free_mode;
    assign free_mode = (cfg_mode == 2'b00) || (cfg_mode == 2'b11);

    AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_act |-> ram_addr_o == '0); // R2

    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !seq_act && ram_addr_o == '0); // R2

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        seq_act && cfg_enable && free_mode && ram_addr_o != LAST
        |=> seq_act && ram_addr_o == $past(ram_addr_o) + 1'b1); // R3

    AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
        seq_act && cfg_enable && free_mode && !cfg_loop && ram_addr_o == LAST
        |=> !seq_act); // R3

    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        seq_act && cfg_enable && free_mode && cfg_loop && ram_addr_o == LAST
        |=> seq_act && ram_addr_o == '0); // R4

    AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        seq_act && cfg_enable && cfg_mode == 2'b01 && !l0_i
        |=> seq_act && $stable(ram_addr_o)); // R6

    AST_CMD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        seq_act && cfg_enable && cfg_mode == 2'b10 && test_cmd_i && ram_addr_o == LAST
        |=> seq_act && ram_addr_o == '0); // R7

    AST_ACTIVE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        seq_active_o == $past(seq_act)); // R9

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_o & UNUSED) == '0); // R10

endmodule

bind tinj_sequencer tinj_sequencer_chk #(
    .ADDR_W (ADDR_W),
    .N_CH   (N_CH),
    .USED_W (USED_W),
    .WORD_W (tinj_pkg::WORD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_loop     (cfg_loop),
    .cfg_mode     (cfg_mode),
    .test_cmd_i   (test_cmd_i),
    .l0_i         (l0_i),
    .ram_addr_o   (ram_addr_o),
    .seq_active_o (seq_active_o),
    .pattern_o    (pattern_o),
    .seq_act      (seq_act)
);

// File: tb/tinj_sequencer_test.sv
module tinj_sequencer_test;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_enable = 1'b0;
    logic           cfg_loop = 1'b0;
    logic [1:0]     cfg_mode = 2'b00;
    logic           test_cmd_i = 1'b0;
    logic           l0_i = 1'b0;
    logic           host_we_i = 1'b0;
    logic [2:0]     host_chan_i = '0;
    logic [7:0]     host_addr_i = '0;
    logic [15:0]    host_data_i = '0;
    logic [7:0]     ram_addr_o;
    logic           seq_active_o;
    logic [NCH*16-1:0] pattern_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    logic       prev_act  = 1'b0;
    logic [7:0] prev_addr = 8'd0;
    bit         pat_ok    = 0;

    always #5 clk = ~clk;

    tinj_sequencer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_enable   (cfg_enable),
        .cfg_loop     (cfg_loop),
        .cfg_mode     (cfg_mode),
        .test_cmd_i   (test_cmd_i),
        .l0_i         (l0_i),
        .host_we_i    (host_we_i),
        .host_chan_i  (host_chan_i),
        .host_addr_i  (host_addr_i),
        .host_data_i  (host_data_i),
        .ram_addr_o   (ram_addr_o),
        .seq_active_o (seq_active_o),
        .pattern_o    (pattern_o)
    );

    function automatic logic [15:0] pat(input int ch, input int a);
        return 16'((ch * 273) + (a * 7) + 16'hB000);
    endfunction

    function automatic logic [NCH*16-1:0] exp_vec(input int a);
        logic [NCH*16-1:0] v;
        for (int c = 0; c < NCH; c++) begin
            v[c*16 +: 16] = pat(c, a) & 16'h0FFF;
        end
        return v;
    endfunction

    task automatic tick(input logic cmd, input logic trg);
        test_cmd_i = cmd;
        l0_i       = trg;
        @(posedge clk);
        @(negedge clk);
        test_cmd_i = 1'b0;
        l0_i       = 1'b0;
    endtask

    // ea/eact: expected address and internal activity after the last edge
    task automatic chk(input logic [7:0] ea, input logic eact, input string tag);
        vectors++;
        if (ram_addr_o !== ea) begin
            misses++;
            $display("FAIL %s address: actual %0d expected %0d", tag, ram_addr_o, ea);
        end
        if (seq_active_o !== prev_act) begin
            misses++;
            $display("FAIL %s R9 active: actual %b expected %b", tag, seq_active_o, prev_act);
        end
        if (pat_ok && pattern_o !== exp_vec(prev_addr)) begin
            misses++;
            $display("FAIL %s pattern (R9 R10 R11): actual %h expected %h",
                     tag, pattern_o, exp_vec(prev_addr));
        end
        prev_act  = eact;
        prev_addr = ea;
    endtask

    task automatic host_write(input int ch, input int a, input logic [15:0] d);
        host_we_i   = 1'b1;
        host_chan_i = 3'(ch);
        host_addr_i = 8'(a);
        host_data_i = d;
        @(posedge clk);
        @(negedge clk);
        host_we_i = 1'b0;
    endtask

    task automatic go_idle(input string tag);
        cfg_enable = 1'b0;
        tick(1'b0, 1'b0);
        chk(8'd0, 1'b0, tag);
        tick(1'b0, 1'b0);
        chk(8'd0, 1'b0, tag);
        cfg_enable = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [7:0] ea;
        logic       eact;

        // R1: reset state
        repeat (3) @(negedge clk);
        vectors++;
        if (ram_addr_o !== 8'd0 || seq_active_o !== 1'b0 || pattern_o !== '0) begin
            misses++;
            $display("FAIL R1 reset: actual %0d/%b/%h expected 0/0/0",
                     ram_addr_o, seq_active_o, pattern_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R11: load every channel through the host port
        for (int c = 0; c < NCH; c++) begin
            for (int a = 0; a < 256; a++) begin
                host_write(c, a, pat(c, a));
            end
        end
        tick(1'b0, 1'b0);
        prev_act  = 1'b0;
        prev_addr = 8'd0;
        pat_ok    = 1;

        // R2: command ignored while disabled
        cfg_enable = 1'b0;
        for (int n = 0; n < 4; n++) begin
            tick(1'b1, 1'b0);
            chk(8'd0, 1'b0, "R2");
        end

        // R3 one-shot, with an ignored command mid-run (R5)
        cfg_enable = 1'b1; cfg_loop = 1'b0; cfg_mode = 2'b00;
        tick(1'b1, 1'b0);
        chk(8'd0, 1'b1, "R3");
        for (int n = 1; n <= 260; n++) begin
            tick(n == 100, 1'b0);
            ea   = (n <= 255) ? 8'(n) : 8'd0;
            eact = (n <= 255);
            chk(ea, eact, (n == 100 || n == 101) ? "R5" : "R3");
        end

        // R4 free loop, then disable (R2)
        cfg_loop = 1'b1;
        tick(1'b1, 1'b0);
        chk(8'd0, 1'b1, "R4");
        for (int n = 1; n <= 600; n++) begin
            tick(1'b0, 1'b0);
            chk(8'(n % 256), 1'b1, "R4");
        end
        go_idle("R2");

        // R6 trigger-stepped, ends at the last address
        cfg_loop = 1'b0; cfg_mode = 2'b01;
        tick(1'b1, 1'b0);
        chk(8'd0, 1'b1, "R6");
        cnt = 0;
        for (int n = 1; cnt < 256; n++) begin
            tick(n == 50, (n % 3) == 0);
            if ((n % 3) == 0) cnt++;
            ea   = (cnt <= 255) ? 8'(cnt) : 8'd0;
            eact = (cnt <= 255);
            chk(ea, eact, (n == 50) ? "R5" : "R6");
        end
        for (int n = 0; n < 3; n++) begin
            tick(1'b0, 1'b1);
            chk(8'd0, 1'b0, "R6");
        end

        // R6 trigger-stepped with wrap
        cfg_loop = 1'b1;
        tick(1'b1, 1'b0);
        chk(8'd0, 1'b1, "R6");
        cnt = 0;
        for (int n = 1; n <= 600; n++) begin
            tick(1'b0, n[0]);
            if (n[0]) cnt++;
            chk(8'(cnt % 256), 1'b1, "R6");
        end
        go_idle("R2");

        // R7 command-stepped wraps even with loop off
        cfg_loop = 1'b0; cfg_mode = 2'b10;
        tick(1'b1, 1'b0);
        chk(8'd0, 1'b1, "R7");
        cnt = 0;
        for (int n = 1; n <= 600; n++) begin
            tick(n[0], 1'b1);
            if (n[0]) cnt++;
            chk(8'(cnt % 256), 1'b1, "R7");
        end
        go_idle("R2");

        // R8 mode 11 matches the one-shot free mode
        cfg_mode = 2'b11;
        tick(1'b1, 1'b0);
        chk(8'd0, 1'b1, "R8");
        for (int n = 1; n <= 258; n++) begin
            tick(n == 7, 1'b0);
            ea   = (n <= 255) ? 8'(n) : 8'd0;
            eact = (n <= 255);
            chk(ea, eact, "R8");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule